// File: doc/BRIEF.md
# Supply-Monitor Reset Sequencer

This block turns two supervisory comparator flags into an active-low system reset. One flag says whether the regulated rail is good and the other whether the battery supply is good. A flag level of 1 means the supply is valid and 0 means it is not. All three inputs are asynchronous to the clock, so each is resynchronized through two flops before any logic uses it.

A release delay starts when the regulator becomes valid. Reset is released only when that delay has fully elapsed and the battery is also valid. If the battery becomes valid late, the release waits only for whatever part of the delay is still left. Short dips of the regulator flag are filtered out by a persistence window. A longer dip drops the regulator state and restarts the full delay. A low battery flag pulls reset low at once.

The reset line can also be pulled low from outside the block. A sense input reports that line, and the block combines it with its own reset decision into two signals. `bridge_inhibit` forces the motor bridge outputs inactive. `reload_strobe` is a single-cycle pulse that reloads the serial input register with its default value. All times are counted in clock cycles.

Top module: `supply_reset_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls with both supply flags at 0, `sys_rst_n` is 0, `bridge_inhibit` is 1 and `reload_strobe` is 0.
- R2: With `bat_ok_raw` already at 1, `sys_rst_n` rises exactly DELAY_CYC+4 cycles after `reg_ok_raw` rises. It is 0 in every cycle before that.
- R3: If `bat_ok_raw` rises after the delay has elapsed, `sys_rst_n` rises exactly 3 cycles later, with no further delay.
- R4: If `bat_ok_raw` rises k cycles after `reg_ok_raw` while the delay is still running, `sys_rst_n` rises at max(DELAY_CYC+4, k+3) cycles after `reg_ok_raw` rises.
- R5: A drop of `reg_ok_raw` to 0 that lasts fewer than PERSIST_CYC cycles leaves `sys_rst_n` at 1 throughout. It also does not restart the delay.
- R6: A drop of `reg_ok_raw` that lasts L >= PERSIST_CYC cycles pulls `sys_rst_n` low PERSIST_CYC+3 cycles after the drop begins. `sys_rst_n` rises again L+DELAY_CYC+4 cycles after the drop begins.
- R7: When `bat_ok_raw` falls to 0, `sys_rst_n` goes low exactly 3 cycles later, even while the regulator is valid.
- R8: `bridge_inhibit` is 1 whenever `sys_rst_n` is 0. It is also 1 from 3 cycles after `ext_rst_n_raw` goes low (0 means the line is held low from outside). `ext_rst_n_raw` never changes `sys_rst_n`.
- R9: `reload_strobe` is a one-cycle pulse. It fires in the cycle in which `bridge_inhibit` goes from 0 to 1. An internal and an external reset that start together give a single pulse. An external reset that starts while reset is already active gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| reg_ok_raw | input | 1 | Regulator comparator flag, 1 = valid, asynchronous |
| bat_ok_raw | input | 1 | Battery comparator flag, 1 = valid, asynchronous |
| ext_rst_n_raw | input | 1 | Sensed level of the shared reset line, 0 = held low |
| sys_rst_n | output | 1 | Active-low system reset drive level |
| bridge_inhibit | output | 1 | Forces motor bridge outputs inactive |
| reload_strobe | output | 1 | One-cycle reload pulse for the serial input register |

## Verification
Two sources can start a reset in the same cycle: the block's own decision, for example a battery drop, and the sensed external reset. Both paths have the same three-cycle latency. Both inputs are therefore changed on the same clock edge, and the bench checks that exactly one reload pulse appears and that it lands in the third cycle. The bench also starts an external reset while the internal reset is already active and checks that no second pulse is produced. Separately, the battery arrival time is swept across the whole delay window, and the regulator drop length is swept across the persistence threshold. Each release time is compared against its closed-form formula.

// File: rtl/supply_rst_pkg.sv
package supply_rst_pkg;
  // Index of each supervisory flag in the synchronizer vector
  localparam int unsigned IDX_REG = 0;
  localparam int unsigned IDX_BAT = 1;
  localparam int unsigned IDX_EXT = 2;
  localparam int unsigned N_FLAGS = 3;

  typedef struct packed {
    logic ext_ok;
    logic bat_ok;
    logic reg_ok;
  } sup_flags_t;

  // Values taken by the synchronizers while the block is in reset:
  // supplies treated as invalid, external line treated as released.
  localparam sup_flags_t FLAGS_RST = '{ext_ok: 1'b1, bat_ok: 1'b0, reg_ok: 1'b0};
endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  localparam int unsigned LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[b]}};
      else     chain <= {chain[STAGES-2:0], d_async[b]};
    end
    assign q_sync[b] = chain[LAST];
  end
endmodule

// File: rtl/drop_filter.sv
module drop_filter #(
  parameter int unsigned PERSIST_CYC = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic flag_in,
  output logic flag_valid
);
  localparam int unsigned CW = (PERSIST_CYC < 2) ? 1 : $clog2(PERSIST_CYC);
  localparam logic [CW-1:0] LIMIT = CW'(PERSIST_CYC - 1);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_valid <= 1'b0;
      low_cnt    <= '0;
    end else if (!flag_valid) begin
      low_cnt <= '0;
      if (flag_in) flag_valid <= 1'b1;
    end else if (flag_in) begin
      low_cnt <= '0;
    end else if (low_cnt == LIMIT) begin
      flag_valid <= 1'b0;
      low_cnt    <= '0;
    end else begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  AST_DROP_PERSISTED: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_valid) |-> ($past(low_cnt) == LIMIT && !$past(flag_in))); // R6
  AST_HIGH_KEEPS_VALID: assert property (@(posedge clk) disable iff (rst)
    (flag_valid && flag_in) |=> flag_valid); // R5
endmodule

// File: rtl/release_timer.sv
module release_timer #(
  parameter int unsigned DELAY_CYC = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic start_valid,
  output logic elapsed
);
  localparam int unsigned CW = (DELAY_CYC < 2) ? 1 : $clog2(DELAY_CYC);
  localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);

  logic [CW-1:0] cyc_cnt;

  always_ff @(posedge clk) begin
    if (rst || !start_valid) begin
      cyc_cnt <= '0;
      elapsed <= 1'b0;
    end else if (!elapsed) begin
      if (cyc_cnt == LAST) elapsed <= 1'b1;
      else                 cyc_cnt <= cyc_cnt + 1'b1;
    end
  end

  AST_ELAPSED_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    elapsed |-> $past(start_valid)); // R2
  AST_ELAPSED_AT_END: assert property (@(posedge clk) disable iff (rst)
    $rose(elapsed) |-> $past(cyc_cnt) == LAST); // R4
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq
  import supply_rst_pkg::*;
#(
  parameter int unsigned DELAY_CYC   = 20,
  parameter int unsigned PERSIST_CYC = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic reg_ok_raw,
  input  logic bat_ok_raw,
  input  logic ext_rst_n_raw,
  output logic sys_rst_n,
  output logic bridge_inhibit,
  output logic reload_strobe
);
  sup_flags_t raw_flags;
  sup_flags_t s_flags;
  logic       reg_valid;
  logic       dly_done;
  logic       int_ok;
  logic       hold_req;

  assign raw_flags = '{ext_ok: ext_rst_n_raw, bat_ok: bat_ok_raw, reg_ok: reg_ok_raw};

  flag_sync #(
    .WIDTH  (N_FLAGS),
    .STAGES (2),
    .RST_VAL(FLAGS_RST)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_async(raw_flags),
    .q_sync (s_flags)
  );

  drop_filter #(.PERSIST_CYC(PERSIST_CYC)) u_filter (
    .clk       (clk),
    .rst       (rst),
    .flag_in   (s_flags.reg_ok),
    .flag_valid(reg_valid)
  );

  release_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .start_valid(reg_valid),
    .elapsed    (dly_done)
  );

  // Own release decision, then merge with the sensed shared line
  assign int_ok   = reg_valid & dly_done & s_flags.bat_ok;
  assign hold_req = ~int_ok | ~s_flags.ext_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_rst_n      <= 1'b0;
      bridge_inhibit <= 1'b1;
      reload_strobe  <= 1'b0;
    end else begin
      sys_rst_n      <= int_ok;
      bridge_inhibit <= hold_req;
      reload_strobe  <= hold_req & ~bridge_inhibit;
    end
  end

  AST_LOW_RST_INHIBITS: assert property (@(posedge clk) disable iff (rst)
    !sys_rst_n |-> bridge_inhibit); // R8
  AST_BAT_LOSS_ASSERTS: assert property (@(posedge clk) disable iff (rst)
    !s_flags.bat_ok |=> !sys_rst_n); // R7
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    reload_strobe |=> !reload_strobe); // R9
  AST_STROBE_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
    reload_strobe |-> (bridge_inhibit && !$past(bridge_inhibit))); // R9
  AST_RELEASE_AFTER_DELAY: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_n) |-> $past(dly_done)); // R2
endmodule

// File: tb/test_supply_reset_seq.sv
module test_supply_reset_seq;
  localparam int D = 20;
  localparam int P = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_ok_raw = 1'b0;
  logic bat_ok_raw = 1'b0;
  logic ext_rst_n_raw = 1'b1;
  logic sys_rst_n, bridge_inhibit, reload_strobe;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk; // 50 MHz

  supply_reset_seq #(.DELAY_CYC(D), .PERSIST_CYC(P)) i_supply_reset_seq (
    .clk(clk), .rst(rst), .reg_ok_raw(reg_ok_raw), .bat_ok_raw(bat_ok_raw),
    .ext_rst_n_raw(ext_rst_n_raw), .sys_rst_n(sys_rst_n),
    .bridge_inhibit(bridge_inhibit), .reload_strobe(reload_strobe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Ticks until sys_rst_n equals lvl (0 if not seen within lim)
  task automatic wait_level(input logic lvl, input int lim, output int t);
    t = 0;
    for (int i = 1; i <= lim; i++) begin
      tick();
      if (sys_rst_n === lvl) begin t = i; return; end
    end
  endtask

  task automatic block_reset();
    rst = 1'b1; reg_ok_raw = 1'b0; bat_ok_raw = 1'b0; ext_rst_n_raw = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
  endtask

  task automatic power_up();
    int t;
    block_reset();
    reg_ok_raw = 1'b1; bat_ok_raw = 1'b1;
    wait_level(1'b1, D + 20, t);
  endtask

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  initial begin
    int t, t2, pulses, pulse_at;
    bit stayed;

    // R1: reset state
    repeat (2) tick();
    chk(sys_rst_n === 1'b0 && bridge_inhibit === 1'b1 && reload_strobe === 1'b0,
        "R1 in reset", {sys_rst_n, bridge_inhibit, reload_strobe}, 3'b010);
    rst = 1'b0;
    tick();
    chk(sys_rst_n === 1'b0 && bridge_inhibit === 1'b1 && reload_strobe === 1'b0,
        "R1 after reset", {sys_rst_n, bridge_inhibit, reload_strobe}, 3'b010);

    // R2: regulator rises with battery valid
    block_reset();
    bat_ok_raw = 1'b1; reg_ok_raw = 1'b1;
    wait_level(1'b1, D + 20, t);
    chk(t == D + 4, "R2 release time", t, D + 4);

    // R3: battery late, after delay elapsed
    block_reset();
    reg_ok_raw = 1'b1;
    repeat (D + 10) tick();
    chk(sys_rst_n === 1'b0, "R3 held without battery", sys_rst_n, 0);
    bat_ok_raw = 1'b1;
    wait_level(1'b1, D + 20, t);
    chk(t == 3, "R3 immediate release", t, 3);

    // R4: sweep battery arrival across the delay window
    for (int k = 0; k <= D + 6; k++) begin
      block_reset();
      reg_ok_raw = 1'b1;
      t = 0;
      for (int i = 1; i <= 2 * D + 20; i++) begin
        if (i - 1 == k) bat_ok_raw = 1'b1;
        tick();
        if (sys_rst_n === 1'b1) begin t = i; break; end
      end
      chk(t == max2(D + 4, k + 3), $sformatf("R4 bat at %0d", k), t, max2(D + 4, k + 3));
    end

    // R5/R6: sweep regulator drop length across the persistence window
    for (int L = 1; L <= P + 3; L++) begin
      power_up();
      reg_ok_raw = 1'b0;
      t = 0; t2 = 0; stayed = 1'b1;
      for (int i = 1; i <= L + D + 12; i++) begin
        if (i - 1 == L) reg_ok_raw = 1'b1;
        tick();
        if (sys_rst_n !== 1'b1) stayed = 1'b0;
        if (t == 0 && sys_rst_n === 1'b0) t = i;
        if (t != 0 && t2 == 0 && sys_rst_n === 1'b1) t2 = i;
      end
      if (L < P) begin
        chk(stayed, $sformatf("R5 short drop %0d", L), stayed, 1);
      end else begin
        chk(t == P + 3, $sformatf("R6 assert after drop %0d", L), t, P + 3);
        chk(t2 == L + D + 4, $sformatf("R6 release after drop %0d", L), t2, L + D + 4);
      end
    end

    // R7: battery loss while regulator valid, then return
    power_up();
    bat_ok_raw = 1'b0;
    wait_level(1'b0, 20, t);
    chk(t == 3, "R7 battery loss latency", t, 3);
    bat_ok_raw = 1'b1;
    wait_level(1'b1, 20, t);
    chk(t == 3, "R3 battery return", t, 3);

    // R8/R9: external reset alone
    power_up();
    tick();
    ext_rst_n_raw = 1'b0;
    pulses = 0; pulse_at = 0; stayed = 1'b1;
    for (int i = 1; i <= 8; i++) begin
      tick();
      if (reload_strobe === 1'b1) begin pulses++; pulse_at = i; end
      if (sys_rst_n !== 1'b1) stayed = 1'b0;
      if (i == 2) chk(bridge_inhibit === 1'b0, "R8 ext inhibit not early", bridge_inhibit, 0);
      if (i == 3) chk(bridge_inhibit === 1'b1, "R8 ext inhibit at 3", bridge_inhibit, 1);
    end
    chk(stayed, "R8 ext leaves sys_rst_n", stayed, 1);
    chk(pulses == 1 && pulse_at == 3, "R9 ext strobe", pulses * 100 + pulse_at, 103);
    ext_rst_n_raw = 1'b1;
    repeat (3) tick();
    chk(bridge_inhibit === 1'b0, "R8 ext release", bridge_inhibit, 0);

    // R9: internal and external reset start on the same edge
    tick();
    ext_rst_n_raw = 1'b0; bat_ok_raw = 1'b0;
    pulses = 0; pulse_at = 0;
    for (int i = 1; i <= 8; i++) begin
      tick();
      if (reload_strobe === 1'b1) begin pulses++; pulse_at = i; end
    end
    chk(pulses == 1 && pulse_at == 3, "R9 coincident single strobe", pulses * 100 + pulse_at, 103);
    chk(sys_rst_n === 1'b0 && bridge_inhibit === 1'b1, "R8 coincident held",
        {sys_rst_n, bridge_inhibit}, 2'b01);

    // R9: external pulse during active internal reset gives no strobe
    ext_rst_n_raw = 1'b1;
    repeat (4) tick();
    ext_rst_n_raw = 1'b0;
    pulses = 0;
    for (int i = 1; i <= 8; i++) begin
      tick();
      if (reload_strobe === 1'b1) pulses++;
    end
    chk(pulses == 0, "R9 no strobe when already active", pulses, 0);
    chk(bridge_inhibit === 1'b1, "R8 inhibit stays", bridge_inhibit, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule